// File: doc/BRIEF.md
# Sound generator register write front end

This block is the processor-facing side of a programmable sound generator. A host drives an 8-bit bus with two active-low strobes, chip enable and write enable. The block brings both strobes into its own clock domain and accepts one byte per chip-enable access. It routes that byte into a bank of eight control registers: three 10-bit tone half-periods, four 4-bit attenuators and one 3-bit noise control word. The register contents drive the tone and noise generators, which are outside this block.

A byte with bit 7 set names its target register. Later bytes with bit 7 clear go to the register named last, so the host can sweep the upper period bits one byte at a time. A READY output holds the host off while each byte is loaded. A one-clock pulse on every noise control write lets the noise generator clear its shift register.

Top module: `psg_regif`

## Requirements
- R1: After reset, READY is high, all three tone periods are 0, all four attenuators are 4'hF and the noise control word is 0.
- R2: A byte with bit 7 = 1 and an even address in bits 6..4 (000, 010, 100 for tones 1, 2, 3) writes bits 3..0 into bits 3..0 of that tone period. Bits 9..4 stay unchanged.
- R3: A byte with bit 7 = 0 writes its bits 5..0 into bits 9..4 of the last addressed tone period. Bits 3..0 stay unchanged. Repeated data bytes keep going to that same register.
- R4: A byte with bit 7 = 1 and an odd address (001, 011, 101, 111 for attenuators 1 to 4) writes bits 3..0 into that attenuator.
- R5: A byte with bit 7 = 1 and address 110 writes bits 2..0 into the noise control word (bit 2 feedback type, bits 1..0 rate). noise_wr_o is high for exactly one clock, in the cycle the new value first appears.
- R6: A byte with bit 7 = 0 sent after an attenuator or noise address writes only the low bits of that register (bits 3..0 or bits 2..0). A noise write made this way also pulses noise_wr_o.
- R7: While chip enable is high, write enable and the data bus have no effect: READY stays high and no register changes.
- R8: When chip enable falls while write enable is high, READY falls SYNC_STAGES+1 clocks later. It stays low until a byte is written.
- R9: After a byte is accepted, READY is low for exactly LOAD_CYCLES clocks and then rises, even if chip enable is still low.
- R10: Only one byte is written per chip-enable access. Toggling write enable again before chip enable rises writes nothing.
- R11: No register changes in any cycle without an accepted write, and a write leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable from host, active low, asynchronous |
| we_ni | input | 1 | Write enable from host, active low, asynchronous |
| data_i | input | 8 | Host data byte, stable while write enable is low |
| ready_o | output | 1 | High when the host may proceed |
| tone_period_o | output | 30 | Three 10-bit tone half-periods, tone 1 in bits 9..0 |
| atten_o | output | 16 | Four 4-bit attenuators, attenuator 1 in bits 3..0 |
| noise_ctl_o | output | 3 | Noise control: bit 2 feedback type, bits 1..0 rate |
| noise_wr_o | output | 1 | One-clock pulse on each noise control write |

## Verification
The bench builds the block with LOAD_CYCLES = 4 and SYNC_STAGES = 2. These are the short-load setting and the usual two-flop synchronizer. With them, every address, both byte formats and the low-bit-only updates fit in a few hundred clocks. The READY latency and load length are measured exactly against SYNC_STAGES+1 and LOAD_CYCLES. The waiting access (chip enable before write enable) and extra write strobes inside one access are driven to confirm that the single-write rule holds.

// File: rtl/psg_regif_pkg.sv
package psg_regif_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int PER_W  = 10;
  localparam int LO_W   = 4;
  localparam int HI_W   = PER_W - LO_W;
  localparam int ATT_W  = 4;
  localparam int NSE_W  = 3;
  localparam int N_TONE = 3;
  localparam int N_ATT  = 4;
  localparam logic [ADDR_W-1:0] ADDR_NOISE = 3'b110;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LOAD,
    ST_DONE
  } acc_state_e;
endpackage

// File: rtl/psg_sync.sv
module psg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     chain_q[s] <= '1;
      else if (s == 0) chain_q[s] <= d_i;
      else             chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/psg_access_fsm.sv
module psg_access_fsm
  import psg_regif_pkg::*;
#(
  parameter int LOAD_CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_s_ni,
  input  logic we_s_ni,
  output logic wr_stb_o,
  output logic ready_o
);
  localparam int CNT_W = $clog2(LOAD_CYCLES + 1);

  acc_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  // accept only before this access has loaded a byte
  assign wr_stb_o = !ce_s_ni && !we_s_ni &&
                    (state_q == ST_IDLE || state_q == ST_WAIT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (wr_stb_o) state_d = ST_LOAD;
               else if (!ce_s_ni) state_d = ST_WAIT;
      ST_WAIT: if (wr_stb_o) state_d = ST_LOAD;
               else if (ce_s_ni) state_d = ST_IDLE;
      ST_LOAD: if (cnt_q == CNT_W'(LOAD_CYCLES - 1))
                 state_d = ce_s_ni ? ST_IDLE : ST_DONE;
      ST_DONE: if (ce_s_ni) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_LOAD) cnt_q <= cnt_q + 1'b1;
      else                    cnt_q <= '0;
    end
  end

  assign ready_o = (state_q == ST_IDLE) || (state_q == ST_DONE);
endmodule

// File: rtl/psg_reg_bank.sv
module psg_reg_bank
  import psg_regif_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_stb_i,
  input  logic [BYTE_W-1:0]       data_i,
  output logic [N_TONE*PER_W-1:0] tone_o,
  output logic [N_ATT*ATT_W-1:0]  atten_o,
  output logic [NSE_W-1:0]        noise_o,
  output logic                    noise_wr_o
);
  logic              is_addr;
  logic [ADDR_W-1:0] lat_q, tgt;

  assign is_addr = data_i[BYTE_W-1];
  assign tgt     = is_addr ? data_i[BYTE_W-2:BYTE_W-1-ADDR_W] : lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  lat_q <= '0;
    else if (wr_stb_i && is_addr) lat_q <= tgt;
  end

  for (genvar t = 0; t < N_TONE; t++) begin : g_tone
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(2 * t);
    logic [PER_W-1:0] per_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) per_q <= '0;
      else if (wr_stb_i && tgt == MY_ADDR) begin
        if (is_addr) per_q[LO_W-1:0]     <= data_i[LO_W-1:0];
        else         per_q[PER_W-1:LO_W] <= data_i[HI_W-1:0];
      end
    end
    assign tone_o[t*PER_W +: PER_W] = per_q;
  end

  for (genvar a = 0; a < N_ATT; a++) begin : g_att
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(2 * a + 1);
    logic [ATT_W-1:0] att_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         att_q <= '1;
      else if (wr_stb_i && tgt == MY_ADDR) att_q <= data_i[ATT_W-1:0];
    end
    assign atten_o[a*ATT_W +: ATT_W] = att_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      noise_o    <= '0;
      noise_wr_o <= 1'b0;
    end else begin
      noise_wr_o <= wr_stb_i && tgt == ADDR_NOISE;
      if (wr_stb_i && tgt == ADDR_NOISE) noise_o <= data_i[NSE_W-1:0];
    end
  end
endmodule

// File: rtl/psg_regif.sv
module psg_regif
  import psg_regif_pkg::*;
#(
  parameter int LOAD_CYCLES = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ce_ni,
  input  logic                    we_ni,
  input  logic [BYTE_W-1:0]       data_i,
  output logic                    ready_o,
  output logic [N_TONE*PER_W-1:0] tone_period_o,
  output logic [N_ATT*ATT_W-1:0]  atten_o,
  output logic [NSE_W-1:0]        noise_ctl_o,
  output logic                    noise_wr_o
);
  logic [1:0] strb_s;
  logic       wr_stb;

  psg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ce_ni, we_ni}),
    .q_o   (strb_s)
  );

  psg_access_fsm #(.LOAD_CYCLES(LOAD_CYCLES)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_s_ni (strb_s[1]),
    .we_s_ni (strb_s[0]),
    .wr_stb_o(wr_stb),
    .ready_o (ready_o)
  );

  psg_reg_bank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_stb_i  (wr_stb),
    .data_i    (data_i),
    .tone_o    (tone_period_o),
    .atten_o   (atten_o),
    .noise_o   (noise_ctl_o),
    .noise_wr_o(noise_wr_o)
  );
endmodule

// File: rtl/psg_regif_chk.sv
module psg_regif_chk #(
  parameter int LOAD_CYCLES = 32
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ready_o,
  input logic        wr_stb_i,
  input logic        noise_wr_o,
  input logic [29:0] tone_period_o,
  input logic [15:0] atten_o,
  input logic [2:0]  noise_ctl_o
);
  logic [15:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 low_run_q <= '0;
    else if (ready_o)            low_run_q <= '0;
    else if (low_run_q != '1)    low_run_q <= low_run_q + 1'b1;
  end

  a_r9_ready_drops_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> !ready_o);

  a_r9_load_not_shortened: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (low_run_q >= 16'(LOAD_CYCLES)));

  a_r10_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> !wr_stb_i);

  a_r5_noise_pulse_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    noise_wr_o |=> !noise_wr_o);

  a_r5_noise_pulse_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    noise_wr_o |-> $past(wr_stb_i));

  a_r11_regs_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> ($stable(tone_period_o) && $stable(atten_o) && $stable(noise_ctl_o)));
endmodule

bind psg_regif psg_regif_chk #(.LOAD_CYCLES(LOAD_CYCLES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .wr_stb_i     (wr_stb),
  .noise_wr_o   (noise_wr_o),
  .tone_period_o(tone_period_o),
  .atten_o      (atten_o),
  .noise_ctl_o  (noise_ctl_o)
);

// File: tb/psg_regif_test.sv
`timescale 1ns/1ps
module psg_regif_test;
  localparam int LOAD = 4;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1;
  logic [7:0]  data = 8'h00;
  logic        ready, noise_wr;
  logic [29:0] tone;
  logic [15:0] att;
  logic [2:0]  nse;

  always #2 clk = ~clk;

  psg_regif #(.LOAD_CYCLES(LOAD), .SYNC_STAGES(SYNC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .data_i(data),
    .ready_o(ready), .tone_period_o(tone), .atten_o(att),
    .noise_ctl_o(nse), .noise_wr_o(noise_wr)
  );

  typedef struct {
    logic [29:0] tone;
    logic [15:0] att;
    logic [2:0]  nse;
    int          low;
    string       req;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0, n_bad = 0;
  int          n_pulse = 0;
  logic [29:0] m_tone = '0;
  logic [15:0] m_att  = 16'hFFFF;
  logic [2:0]  m_nse  = '0;
  logic [2:0]  m_lat  = '0;
  bit          done = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model of the register map
  task automatic model(logic [7:0] b);
    logic [2:0] t;
    t = b[7] ? b[6:4] : m_lat;
    if (b[7]) m_lat = b[6:4];
    if (t == 3'b110) m_nse = b[2:0];
    else if (t[0]) m_att[t[2:1]*4 +: 4] = b[3:0];
    else if (b[7]) m_tone[t[2:1]*10 +: 4] = b[3:0];
    else m_tone[t[2:1]*10 + 4 +: 6] = b[5:0];
  endtask

  task automatic push(int low, string req);
    exp_t e;
    e.tone = m_tone; e.att = m_att; e.nse = m_nse; e.low = low; e.req = req;
    q.push_back(e);
  endtask

  task automatic wait_ready(logic lvl, int lim);
    for (int i = 0; i < lim; i++) begin
      if (ready == lvl) return;
      @(negedge clk);
    end
  endtask

  task automatic release_bus();
    ce_n = 1'b1; we_n = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
  endtask

  task automatic write_byte(logic [7:0] b, string req);
    model(b);
    push(LOAD, req);
    data = b; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    wait_ready(1'b0, 20);
    wait_ready(1'b1, 200);
    @(negedge clk);
    release_bus();
  endtask

  // monitor: compare on every READY rise
  logic prev_rdy = 1'b1;
  int   low_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (noise_wr) n_pulse++;
      if (ready && !prev_rdy) begin
        if (q.size() == 0) chk(0, "R9", "unexpected ready rise", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(tone == e.tone, e.req, "tone periods", tone, e.tone);
          chk(att == e.att, e.req, "attenuators", att, e.att);
          chk(nse == e.nse, e.req, "noise ctl", nse, e.nse);
          if (e.low > 0) chk(low_cnt == e.low, "R9", "ready low cycles", low_cnt, e.low);
        end
      end
      low_cnt  = ready ? 0 : low_cnt + 1;
      prev_rdy = ready;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk(ready == 1'b1, "R1", "ready", ready, 1);
    chk(tone == '0, "R1", "tones", tone, 0);
    chk(att == 16'hFFFF, "R1", "atten", att, 16'hFFFF);
    chk(nse == '0, "R1", "noise", nse, 0);

    write_byte(8'h8A, "R2");               // tone1 low = A
    write_byte(8'h3F, "R3");               // tone1 high = 3F
    write_byte(8'h15, "R3");               // sweep: tone1 high = 15
    write_byte(8'hA5, "R2");               // tone2 low = 5
    write_byte(8'h2C, "R3");
    write_byte(8'hC3, "R2");               // tone3 low = 3
    write_byte(8'h01, "R3");
    write_byte(8'h92, "R4");               // atten1
    write_byte(8'hB7, "R4");               // atten2
    write_byte(8'hD0, "R4");               // atten3
    write_byte(8'hF9, "R4");               // atten4
    write_byte(8'h05, "R6");               // data byte -> atten4 low bits
    chk(n_pulse == 0, "R5", "noise pulses before noise write", n_pulse, 0);
    write_byte(8'hE6, "R5");               // noise = 110
    chk(n_pulse == 1, "R5", "noise pulse count", n_pulse, 1);
    write_byte(8'h3B, "R6");               // data byte -> noise = 011
    chk(n_pulse == 2, "R6", "noise pulse on data byte", n_pulse, 2);

    // R7: write enable without chip enable
    data = 8'h81; we_n = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(ready == 1'b1, "R7", "ready with ce high", ready, 1);
    end
    we_n = 1'b1;
    repeat (SYNC + 2) @(negedge clk);
    chk(tone == m_tone, "R7", "tones untouched", tone, m_tone);
    chk(att == m_att, "R7", "atten untouched", att, m_att);
    chk(nse == m_nse, "R7", "noise untouched", nse, m_nse);

    // R8: chip enable first, write later
    ce_n = 1'b0;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      n++;
      if (!ready) break;
    end
    chk(n == SYNC + 1, "R8", "ready fall latency", n, SYNC + 1);
    repeat (5) @(negedge clk);
    chk(ready == 1'b0, "R8", "ready held low while waiting", ready, 0);
    data = 8'h84;
    model(8'h84);
    push(0, "R8");
    we_n = 1'b0;
    @(negedge clk);
    wait_ready(1'b0, 20);
    wait_ready(1'b1, 200);
    // R10: extra strobes inside the same access
    for (int k = 0; k < 3; k++) begin
      we_n = 1'b1; data = 8'h8F;
      repeat (SYNC + 2) @(negedge clk);
      we_n = 1'b0;
      repeat (SYNC + 2) @(negedge clk);
      chk(ready == 1'b1, "R10", "ready stays high", ready, 1);
    end
    release_bus();
    chk(tone == m_tone, "R10", "tones after extra strobes", tone, m_tone);
    chk(att == m_att, "R10", "atten after extra strobes", att, m_att);

    // access with no write: ready returns on release, nothing changes
    push(0, "R11");
    ce_n = 1'b0;
    repeat (SYNC + 6) @(negedge clk);
    release_bus();
    chk(q.size() == 0, "R11", "pending expectations", q.size(), 0);
    chk(n_pulse == 2, "R11", "no stray noise pulse", n_pulse, 2);

    done = 1;
    summary();
  end
endmodule